// File: doc/BRIEF.md
# External Bus Zone Controller

This block sits between a CPU's memory request port and an external bus. It turns each request address into one of five external zones, numbered 0, 1, 2, 6 and 7. It drives three active-low chip selects: zones 0 and 1 share one pin, zone 2 has a pin of its own, and zones 6 and 7 share the third. Each access is held open for a minimum time before it completes. That time is the zone's programmed wait count, and no zone can ever run with zero waits. A zone can also be set to keep the access open until an external ready input is seen high.

A boot-mode pin is captured while reset is held. The captured bit decides what answers the topmost address region. When the bit is high, zone 7 answers, so vector fetches go to the external bus. When it is low, an internal boot ROM is selected instead. Software can overwrite this bit, along with the per-zone settings, through a small register write port. Addresses outside the five zones are completed at once without any chip select.

Top module: `ext_zone_ctrl`

## Requirements
- R1: The region is taken from the top three address bits. Region 0 or 1 drives `cs01_n` low, region 2 drives `cs2_n` low, region 6 drives `cs67_n` low, and region 7 drives `cs67_n` low when the mode bit is 1. Regions 3, 4 and 5 assert no chip select, and `done` follows one cycle after acceptance.
- R2: At most one chip select is low at any time. The chip select for an access stays low from the cycle after acceptance through the cycle in which `done` is high.
- R3: With a programmed wait count W of 1 or more, `done` is high in cycle W+2 after the clock edge that accepts the request. This holds when ready sampling is off, or when ready is already high.
- R4: A programmed wait count of 0 behaves as 1, so `done` is high in cycle 3.
- R5: After reset, every zone has a wait count of 31 and ready sampling off, so `done` is high in cycle 33.
- R6: With ready sampling on, the access stays open after the waits expire until `ready` is sampled high on a clock edge. `done` follows in the next cycle. A high `ready` during the waits does not shorten the access.
- R7: With ready sampling off, the level of `ready` has no effect on access length.
- R8: While `rst_n` is low, the mode bit tracks `boot_mode_pin`. It keeps the value held at reset release.
- R9: With the mode bit at 0, a region 7 access asserts `rom_sel` together with `done` one cycle after acceptance, and asserts no chip select. The mode bit is written at `cfg_addr` 5, bit 0. It does not change the handling of region 6.
- R10: `done` is high for exactly one cycle per access. All chip selects are high in the cycle after `done`.
- R11: `cfg_addr` values 0 to 4 select the settings for zones 0, 1, 2, 6 and 7 in that order. In each, `cfg_wdata[4:0]` is the wait count and `cfg_wdata[5]` enables ready sampling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_mode_pin | input | 1 | Boot-mode level, captured during reset |
| req | input | 1 | Access request, accepted when the block is idle |
| addr | input | ADDR_W | Request word address |
| ready | input | 1 | External ready |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register select |
| cfg_wdata | input | 8 | Configuration write data |
| done | output | 1 | One-cycle access completion strobe |
| cs01_n | output | 1 | Chip select shared by zones 0 and 1 |
| cs2_n | output | 1 | Chip select for zone 2 |
| cs67_n | output | 1 | Chip select shared by zones 6 and 7 |
| rom_sel | output | 1 | Boot ROM answers this access |

## Verification
The bench measures the latency of each access from the accepting edge to `done`, and it checks which pin is low at completion.

- **Programmed zero waits.** This case must take three cycles. A design that allowed zero waits would finish in two.
- **Ready arriving during the waits.** This must not cut the access short. A design that sampled ready too early would complete before the count ran out.
- **Ready arriving long after the waits.** This must stretch the access by exactly the stall. An off-by-one in the stall path would show up as a latency that is one cycle off.
- **Boot-mode pin and software mode writes.** The bench resets with the pin at both levels, then rewrites the mode bit. A design that moved region 6 with the mode, or sent region 7 to a chip select while in ROM mode, would miscompare.
- **Back-to-back accesses.** The bench checks the one-cycle idle gap between accesses.

// File: rtl/ezc_pkg.sv
package ezc_pkg;
    parameter int WAIT_W = 5;
    parameter int NZONE  = 5;
    localparam int SLOT_W = $clog2(NZONE);

    typedef enum logic [1:0] {
        GRP_01   = 2'd0,
        GRP_2    = 2'd1,
        GRP_67   = 2'd2,
        GRP_NONE = 2'd3
    } cs_grp_e;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_ACC  = 2'd1,
        SEQ_DONE = 2'd2
    } seq_st_e;

    typedef struct packed {
        logic              rdy_en;
        logic [WAIT_W-1:0] waits;
    } zone_cfg_t;
endpackage

// File: rtl/ezc_cfg_regs.sv
module ezc_cfg_regs
    import ezc_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   boot_mode_pin,
    input  logic                   cfg_we,
    input  logic [2:0]             cfg_addr,
    input  logic [7:0]             cfg_wdata,
    output zone_cfg_t [NZONE-1:0]  zone_cfg,
    output logic                   mode_ext
);
    localparam logic [2:0] MODE_ADDR = 3'(NZONE);

    typedef struct packed {
        zone_cfg_t [NZONE-1:0] zc;
        logic                  mode;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (cfg_we) begin
            for (int i = 0; i < NZONE; i++) begin
                if (cfg_addr == 3'(i)) begin
                    r_d.zc[i].waits  = cfg_wdata[WAIT_W-1:0];
                    r_d.zc[i].rdy_en = cfg_wdata[WAIT_W];
                end
            end
            if (cfg_addr == MODE_ADDR)
                r_d.mode = cfg_wdata[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NZONE; i++) begin
                r_q.zc[i].waits  <= '1;
                r_q.zc[i].rdy_en <= 1'b0;
            end
            r_q.mode <= boot_mode_pin;
        end else begin
            r_q <= r_d;
        end
    end

    assign zone_cfg = r_q.zc;
    assign mode_ext = r_q.mode;

    // R11
    cfg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == 3'd2) |=> (zone_cfg[2].waits == $past(cfg_wdata[WAIT_W-1:0])));
endmodule

// File: rtl/ezc_decode.sv
module ezc_decode
    import ezc_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              mode_ext,
    output logic [SLOT_W-1:0] slot,
    output cs_grp_e           grp,
    output logic              rom_hit
);
    logic [2:0] region;
    assign region = addr[ADDR_W-1 -: 3];

    always_comb begin
        slot    = '0;
        grp     = GRP_NONE;
        rom_hit = 1'b0;
        case (region)
            3'd0: begin slot = SLOT_W'(0); grp = GRP_01; end
            3'd1: begin slot = SLOT_W'(1); grp = GRP_01; end
            3'd2: begin slot = SLOT_W'(2); grp = GRP_2;  end
            3'd6: begin slot = SLOT_W'(3); grp = GRP_67; end
            3'd7: begin
                slot = SLOT_W'(4);
                if (mode_ext) grp = GRP_67;
                else          rom_hit = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/ezc_seq.sv
module ezc_seq
    import ezc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      req,
    input  cs_grp_e   grp,
    input  logic      rom_hit,
    input  zone_cfg_t zcfg,
    input  logic      ready,
    output logic      done,
    output logic      cs01_n,
    output logic      cs2_n,
    output logic      cs67_n,
    output logic      rom_sel
);
    typedef struct packed {
        seq_st_e           st;
        logic [WAIT_W-1:0] cnt;
        cs_grp_e           grp;
        logic              rdy_en;
        logic              rom;
    } seq_t;

    seq_t s_d, s_q;
    logic [WAIT_W-1:0] eff_wait;

    assign eff_wait = (zcfg.waits == '0) ? WAIT_W'(1) : zcfg.waits;

    always_comb begin
        s_d = s_q;
        case (s_q.st)
            SEQ_IDLE: begin
                if (req) begin
                    s_d.grp    = grp;
                    s_d.rom    = rom_hit;
                    s_d.rdy_en = zcfg.rdy_en;
                    s_d.cnt    = eff_wait;
                    s_d.st     = (grp == GRP_NONE) ? SEQ_DONE : SEQ_ACC;
                end
            end
            SEQ_ACC: begin
                if (s_q.cnt != '0)
                    s_d.cnt = s_q.cnt - 1'b1;
                else if (!s_q.rdy_en || ready)
                    s_d.st = SEQ_DONE;
            end
            SEQ_DONE: begin
                s_d.st  = SEQ_IDLE;
                s_d.grp = GRP_NONE;
                s_d.rom = 1'b0;
            end
            default: s_d.st = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st     <= SEQ_IDLE;
            s_q.cnt    <= '0;
            s_q.grp    <= GRP_NONE;
            s_q.rdy_en <= 1'b0;
            s_q.rom    <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    logic busy;
    assign busy    = (s_q.st != SEQ_IDLE);
    assign cs01_n  = !(busy && s_q.grp == GRP_01);
    assign cs2_n   = !(busy && s_q.grp == GRP_2);
    assign cs67_n  = !(busy && s_q.grp == GRP_67);
    assign done    = (s_q.st == SEQ_DONE);
    assign rom_sel = done && s_q.rom;

    logic cs_any;
    assign cs_any = !(cs01_n && cs2_n && cs67_n);

    // R2
    one_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({~cs01_n, ~cs2_n, ~cs67_n}) <= 1);
    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R10
    cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (cs01_n && cs2_n && cs67_n));
    // R4
    min_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_any) |=> !done);
    // R6
    ready_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == SEQ_ACC && s_q.cnt == '0 && s_q.rdy_en && !ready) |=> !done);
    // R9
    rom_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rom_sel |-> !cs_any);
endmodule

// File: rtl/ext_zone_ctrl.sv
module ext_zone_ctrl
    import ezc_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boot_mode_pin,
    input  logic              req,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ready,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_addr,
    input  logic [7:0]        cfg_wdata,
    output logic              done,
    output logic              cs01_n,
    output logic              cs2_n,
    output logic              cs67_n,
    output logic              rom_sel
);
    zone_cfg_t [NZONE-1:0] zone_cfg;
    zone_cfg_t             sel_cfg;
    logic                  mode_ext;
    logic [SLOT_W-1:0]     slot;
    cs_grp_e               grp;
    logic                  rom_hit;

    ezc_cfg_regs u_regs (
        .clk(clk), .rst_n(rst_n), .boot_mode_pin(boot_mode_pin),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .zone_cfg(zone_cfg), .mode_ext(mode_ext)
    );

    ezc_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr(addr), .mode_ext(mode_ext),
        .slot(slot), .grp(grp), .rom_hit(rom_hit)
    );

    always_comb begin
        sel_cfg = zone_cfg[0];
        for (int i = 0; i < NZONE; i++)
            if (slot == SLOT_W'(i)) sel_cfg = zone_cfg[i];
    end

    ezc_seq u_seq (
        .clk(clk), .rst_n(rst_n), .req(req), .grp(grp), .rom_hit(rom_hit),
        .zcfg(sel_cfg), .ready(ready), .done(done),
        .cs01_n(cs01_n), .cs2_n(cs2_n), .cs67_n(cs67_n), .rom_sel(rom_sel)
    );
endmodule

// File: tb/sim_ext_zone_ctrl.sv
module sim_ext_zone_ctrl;
    localparam int AW = 19;

    logic clk = 1'b0, rst_n = 1'b0, boot_mode_pin = 1'b1;
    logic req = 1'b0, ready = 1'b0, cfg_we = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [2:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic done, cs01_n, cs2_n, cs67_n, rom_sel;

    always #4 clk = ~clk;

    ext_zone_ctrl #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .boot_mode_pin(boot_mode_pin), .req(req),
        .addr(addr), .ready(ready), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .done(done), .cs01_n(cs01_n), .cs2_n(cs2_n),
        .cs67_n(cs67_n), .rom_sel(rom_sel)
    );

    typedef struct {
        int    lat;
        int    grp;   // 0: cs01, 1: cs2, 2: cs67, 3: none
        logic  rom;
        string tag;
    } exp_t;

    exp_t q[$];
    int n_chk = 0, n_bad = 0;
    int cyc = 0, t0 = 0;
    logic gap_pending = 1'b0;
    string gap_tag;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input string msg);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: %s", tag, msg);
        end
    endtask

    // monitor
    always @(negedge clk) begin
        if (gap_pending) begin
            gap_pending = 1'b0;
            check(cs01_n && cs2_n && cs67_n && !done, gap_tag,
                  $sformatf("after done: cs=%b%b%b done=%b, expected cs=111 done=0",
                            cs01_n, cs2_n, cs67_n, done));
        end
        if (rst_n && done) begin
            if (q.size() == 0) begin
                check(1'b0, "R10", "done with no pending access, expected none");
            end else begin
                exp_t e;
                logic [2:0] exp_cs;
                e = q.pop_front();
                exp_cs = (e.grp == 0) ? 3'b011 : (e.grp == 1) ? 3'b101 :
                         (e.grp == 2) ? 3'b110 : 3'b111;
                check(cyc - t0 == e.lat, e.tag,
                      $sformatf("latency %0d, expected %0d", cyc - t0, e.lat));
                check({cs01_n, cs2_n, cs67_n} == exp_cs, e.tag,
                      $sformatf("cs=%b, expected %b", {cs01_n, cs2_n, cs67_n}, exp_cs));
                check(rom_sel == e.rom, e.tag,
                      $sformatf("rom_sel=%b, expected %b", rom_sel, e.rom));
                gap_pending = 1'b1;
                gap_tag = "R10";
            end
        end
    end

    task automatic cfg_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // drive one request and queue its expectation; returns one cycle later
    task automatic issue(input logic [2:0] region, input int lat, input int grp,
                         input logic rom, input string tag);
        exp_t e;
        e.lat = lat; e.grp = grp; e.rom = rom; e.tag = tag;
        @(negedge clk);
        q.push_back(e);
        addr = {region, 16'h0123};
        req = 1'b1;
        t0 = cyc;
        @(negedge clk);
        req = 1'b0;
    endtask

    task automatic drain();
        while (q.size() != 0) @(negedge clk);
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset(input logic pin);
        @(negedge clk);
        rst_n = 1'b0; boot_mode_pin = pin;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        boot_mode_pin = ~pin;   // later pin level must not matter (R8)
    endtask

    initial begin
        fork
            begin
                do_reset(1'b1);
                check(cs01_n && cs2_n && cs67_n && !done && !rom_sel, "R2",
                      $sformatf("reset outputs cs=%b%b%b done=%b rom=%b, expected 111 0 0",
                                cs01_n, cs2_n, cs67_n, done, rom_sel));
                // R5 reset waits = 31
                issue(3'd0, 33, 0, 1'b0, "R5"); drain();
                issue(3'd7, 33, 2, 1'b0, "R8"); drain();
                // R11 program zones
                cfg_write(3'd1, 8'h03);
                cfg_write(3'd2, 8'h00);
                cfg_write(3'd3, 8'h04);
                cfg_write(3'd4, 8'h02);
                issue(3'd1, 5, 0, 1'b0, "R3"); drain();
                issue(3'd2, 3, 1, 1'b0, "R4"); drain();
                issue(3'd6, 6, 2, 1'b0, "R1"); drain();
                issue(3'd7, 4, 2, 1'b0, "R1"); drain();
                issue(3'd4, 1, 3, 1'b0, "R1"); drain();
                // R7 ready ignored when disabled
                ready = 1'b0;
                issue(3'd1, 5, 0, 1'b0, "R7"); drain();
                // R6 ready stall: zone 2 waits 2, ready raised late
                cfg_write(3'd2, 8'h22);
                ready = 1'b0;
                issue(3'd2, 7, 1, 1'b0, "R6");
                repeat (5) @(negedge clk);
                ready = 1'b1;
                drain();
                // R6 early ready does not shorten
                cfg_write(3'd2, 8'h23);
                ready = 1'b1;
                issue(3'd2, 5, 1, 1'b0, "R6"); drain();
                ready = 1'b0;
                // back-to-back accesses, gap checked by monitor (R10)
                issue(3'd0, 33, 0, 1'b0, "R10");
                while (q.size() != 0) @(negedge clk);
                issue(3'd1, 5, 0, 1'b0, "R10"); drain();
                // R9 software clears mode bit
                cfg_write(3'd5, 8'h00);
                issue(3'd7, 1, 3, 1'b1, "R9"); drain();
                issue(3'd6, 6, 2, 1'b0, "R9"); drain();
                // R8 reset with pin low selects ROM
                do_reset(1'b0);
                issue(3'd7, 1, 3, 1'b1, "R8"); drain();
                cfg_write(3'd5, 8'h01);
                issue(3'd7, 33, 2, 1'b0, "R9"); drain();
                check(q.size() == 0, "R10",
                      $sformatf("%0d accesses never completed, expected 0", q.size()));
            end
            begin
                repeat (20000) @(negedge clk);
                check(1'b0, "R10", "watchdog expired, expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule